// File: doc/BRIEF.md
# Waveform Sequencer

This block plays a waveform program held in a synchronous single-cycle-latency memory. It drives the read address, takes each returned word and acts on it. A word can be an output sample, a repeat-hold of the current sample, a jump to a fixed address, or a jump by a signed distance from the jump word's own address. The memory's write side belongs to the host and sits outside the block.

Fetch and decode are two separate register stages, so memory access time and decode logic never share one clock period. A jump or a hold that is taken discards the word already in flight and fetches again from the new address. This refetch costs one dead cycle. After a start pulse the sequencer runs until reset, and the program forms its own loop through jumps.

Top module: `wave_seq`

## Requirements
- R1: A program word is 18 bits. Bits [17:16] hold the opcode: 00 sample, 01 hold, 10 absolute jump, 11 relative jump. Bits [15:0] hold the operand: the sample value, the hold count, the target address, or a two's-complement offset.
- R2: During and after reset, `busy`, `wave_valid`, `wave_out` and `ram_addr` are all zero, and they stay that way until `start` is seen.
- R3: `start` while idle sets `busy` and starts fetching at address 0. `busy` then stays high until reset, and a further `start` pulse has no effect on the output stream.
- R4: A sample word whose address is on `ram_addr` in cycle c puts its operand on `wave_out`, with `wave_valid` high for one cycle, in cycle c+2. Consecutive sample words come out in consecutive cycles.
- R5: With no jump or hold pending, `ram_addr` rises by one each cycle and wraps from 0xFFFF to 0x0000.
- R6: An absolute jump produces two cycles with `wave_valid` low: its own slot and one bubble. The next word fetched is the one at the operand address. The word after the jump is never output.
- R7: A relative jump fetches next from the jump word's address plus the signed operand, modulo 2^16, with the same two invalid cycles as R6.
- R8: A hold with count N>0 keeps `wave_out` and drives `wave_valid` high for N cycles, starting in its own slot. One invalid cycle follows, then execution continues at the word after the hold.
- R9: A hold with count 0 gives exactly one invalid cycle and does not stall. The next word follows directly.
- R10: `wave_out` changes only when a sample word is output. A hold that runs before any sample repeats the reset value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin playing from address 0 when idle |
| ram_rdata | input | 18 | Word read from memory, valid one cycle after its address |
| ram_addr | output | 16 | Read address to memory (registered) |
| wave_out | output | 16 | Current waveform sample (registered) |
| wave_valid | output | 1 | High in each cycle that emits a sample |
| busy | output | 1 | High from start until reset |

## Verification
Straight-line runs of samples show whether the two-cycle latency holds and whether samples come out back to back. Loops closed by absolute jumps show whether the fetched-ahead word is dropped. A sweep of hold counts from 0 to 4, with a hold placed before the first sample, separates the zero-count case, the stall length and the refetch bubble, and also covers the retained reset value. A sweep of relative offsets, both backward and forward, plus a jump to address 0xFFFF, shows whether the offset is taken from the jump word's own address and whether the 16-bit arithmetic wraps.

// File: rtl/wave_seq_pkg.sv
// Shared definitions for the waveform sequencer.
// Assumes the opcode sits in the two most significant bits of each word.
package wave_seq_pkg;
    typedef enum logic [1:0] {
        OP_SAMPLE = 2'b00,
        OP_HOLD   = 2'b01,
        OP_JABS   = 2'b10,
        OP_JREL   = 2'b11
    } wop_e;
endpackage

// File: rtl/wave_seq_fetch.sv
// Fetch stage: owns the program counter (which is also the read address),
// the busy flag and the tag for the word that is in flight.
// Assumes the memory returns mem[pc] one cycle after pc is presented.
module wave_seq_fetch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          redirect,
    input  logic [AW-1:0] redir_pc,
    input  logic          stall,
    output logic [AW-1:0] pc,
    output logic          busy,
    output logic          d_valid,
    output logic [AW-1:0] d_addr
);
    // Advance, redirect or freeze the program counter and tag the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            busy    <= 1'b0;
            d_valid <= 1'b0;
            d_addr  <= '0;
        end else if (!busy) begin
            d_valid <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                pc   <= '0;
            end
        end else if (redirect) begin
            pc      <= redir_pc;
            d_valid <= 1'b0;
        end else if (stall) begin
            d_valid <= 1'b0;
        end else begin
            d_valid <= 1'b1;
            d_addr  <= pc;
            pc      <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/wave_seq_decode.sv
// Decode stage: classifies the returned word and computes any new fetch
// address. Purely combinational. Assumes DW >= AW.
module wave_seq_decode
    import wave_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          d_valid,
    input  logic [AW-1:0] d_addr,
    input  logic [DW+1:0] word,
    output logic          smp_go,
    output logic [DW-1:0] smp_val,
    output logic          hold_go,
    output logic [DW-1:0] hold_n,
    output logic          redirect,
    output logic [AW-1:0] redir_pc
);
    wop_e          op;
    logic [DW-1:0] opd;

    assign op  = wop_e'(word[DW+1:DW]);
    assign opd = word[DW-1:0];

    // Turn the opcode into actions for the output stage, the counter and fetch.
    always_comb begin
        smp_go   = 1'b0;
        smp_val  = opd;
        hold_go  = 1'b0;
        hold_n   = opd;
        redirect = 1'b0;
        redir_pc = d_addr + 1'b1;
        if (d_valid) begin
            case (op)
                OP_SAMPLE: smp_go = 1'b1;
                OP_HOLD: begin
                    hold_go  = (opd != '0);
                    redirect = (opd != '0);
                end
                OP_JABS: begin
                    redirect = 1'b1;
                    redir_pc = opd[AW-1:0];
                end
                default: begin
                    redirect = 1'b1;
                    redir_pc = d_addr + opd[AW-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/wave_seq_hold.sv
// Hold counter: counts down the repeats still owed after a hold's first
// cycle and stalls fetch while any remain.
module wave_seq_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_go,
    input  logic [DW-1:0] hold_n,
    output logic          stall
);
    logic [DW-1:0] left_q;

    // Load the owed repeats on a hold, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (hold_go)
            left_q <= hold_n - 1'b1;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign stall = (left_q != '0);
endmodule

// File: rtl/wave_seq.sv
// Waveform sequencer top: fetch, decode, hold counter and the registered
// output. Assumes a memory with one cycle of read latency and registered address.
module wave_seq #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW+1:0] ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] wave_out,
    output logic          wave_valid,
    output logic          busy
);
    logic          d_valid;
    logic [AW-1:0] d_addr;
    logic          smp_go;
    logic [DW-1:0] smp_val;
    logic          hold_go;
    logic [DW-1:0] hold_n;
    logic          redirect;
    logic [AW-1:0] redir_pc;
    logic          stall;

    wave_seq_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start),
        .redirect(redirect), .redir_pc(redir_pc), .stall(stall),
        .pc(ram_addr), .busy(busy), .d_valid(d_valid), .d_addr(d_addr)
    );

    wave_seq_decode #(.AW(AW), .DW(DW)) u_dec (
        .d_valid(d_valid), .d_addr(d_addr), .word(ram_rdata),
        .smp_go(smp_go), .smp_val(smp_val),
        .hold_go(hold_go), .hold_n(hold_n),
        .redirect(redirect), .redir_pc(redir_pc)
    );

    wave_seq_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .hold_go(hold_go), .hold_n(hold_n),
        .stall(stall)
    );

    // Register the sample and the strobe; holds re-emit the retained value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_out   <= '0;
            wave_valid <= 1'b0;
        end else begin
            wave_valid <= smp_go | hold_go | stall;
            if (smp_go)
                wave_out <= smp_val;
        end
    end
endmodule

// File: rtl/wave_seq_chk.sv
// Property checker for the waveform sequencer, bound into every instance.
module wave_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          wave_valid,
    input logic [DW-1:0] wave_out,
    input logic [AW-1:0] ram_addr,
    input logic          redirect,
    input logic [AW-1:0] redir_pc,
    input logic          stall
);
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wave_valid);

    a_r3_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy);

    a_r3_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ram_addr == '0));

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !redirect && !stall) |=> (ram_addr == AW'($past(ram_addr) + 1)));

    a_r7_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (ram_addr == $past(redir_pc)));

    a_r8_hold_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (wave_valid && (wave_out == $past(wave_out))));
endmodule

bind wave_seq wave_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wave_valid(wave_valid),
    .wave_out(wave_out), .ram_addr(ram_addr), .redirect(redirect),
    .redir_pc(redir_pc), .stall(stall)
);

// File: tb/wave_seq_tb.sv
`timescale 1ns/1ps
module wave_seq_tb;
    localparam int MAXL = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] ram_rdata;
    logic [15:0] ram_addr;
    logic [15:0] wave_out;
    logic        wave_valid;
    logic        busy;

    logic [17:0] mem [0:255];
    logic        ev [0:MAXL-1];
    logic [15:0] ed [0:MAXL-1];
    int          np;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    wave_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr), .wave_out(wave_out), .wave_valid(wave_valid),
        .busy(busy)
    );

    // Behavioural memory, one cycle of read latency, aliased on 8 address bits.
    always_ff @(posedge clk) ram_rdata <= mem[ram_addr[7:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic void push(input logic v, input logic [15:0] d);
        if (np < MAXL) begin
            ev[np] = v;
            ed[np] = d;
        end
        np++;
    endfunction

    // Expected per-cycle stream from the word format (R1) and timing rules R4-R10.
    task automatic build_model(input int len);
        logic [15:0] p = '0;
        logic [15:0] last = '0;
        np = 0;
        while (np < len) begin
            logic [17:0] w = mem[p[7:0]];
            case (w[17:16])
                2'b00: begin last = w[15:0]; push(1'b1, last); p = p + 16'd1; end
                2'b01: begin
                    for (int i = 0; i < int'(w[15:0]); i++) push(1'b1, last);
                    push(1'b0, last);
                    p = p + 16'd1;
                end
                2'b10: begin push(1'b0, last); push(1'b0, last); p = w[15:0]; end
                default: begin push(1'b0, last); push(1'b0, last); p = p + w[15:0]; end
            endcase
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 18'h0;
    endtask

    task automatic run_prog(input string tag, input int len, input bit mid_start,
                            input bit want_ffff, input bit check_reset);
        bit saw = 1'b0;
        build_model(len);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        if (check_reset) begin
            // R2: idle state after reset before any start
            chk(busy === 1'b0, "R2 busy", 32'(busy), 0);
            chk(wave_valid === 1'b0, "R2 valid", 32'(wave_valid), 0);
            chk(wave_out === 16'h0, "R2 out", 32'(wave_out), 0);
            chk(ram_addr === 16'h0, "R2 addr", 32'(ram_addr), 0);
        end
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R3: busy set, fetch at address 0
        chk(busy === 1'b1 && ram_addr === 16'h0, "R3 start", {15'h0, busy, ram_addr}, 32'h1_0000);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (ram_addr === 16'hFFFF) saw = 1'b1;
            chk(wave_valid === ev[i] && wave_out === ed[i], tag,
                {15'h0, wave_valid, wave_out}, {15'h0, ev[i], ed[i]});
            if (mid_start) start = (i == 10);
        end
        start = 1'b0;
        if (want_ffff) chk(saw, "R5 R7 wrap to FFFF", 32'(saw), 1);
    endtask

    initial begin
        // R1 R4 R6 R3: samples, absolute loop, skipped words, start while busy
        clear_mem();
        mem[0] = {2'b00, 16'h1111};
        mem[1] = {2'b00, 16'h2222};
        mem[2] = {2'b00, 16'h3333};
        mem[3] = {2'b10, 16'h0006};
        mem[4] = {2'b00, 16'hDEAD};
        mem[5] = {2'b00, 16'hBEEF};
        mem[6] = {2'b00, 16'h4444};
        mem[7] = {2'b10, 16'h0001};
        run_prog("R1 R3 R4 R6 stream", 40, 1'b1, 1'b0, 1'b1);

        // R8 R9 R10: hold count sweep, hold placed before the first sample
        for (int n = 0; n < 5; n++) begin
            clear_mem();
            mem[0] = {2'b01, 16'h0002};
            mem[1] = {2'b00, 16'h1200 + 16'(n)};
            mem[2] = {2'b01, 16'(n)};
            mem[3] = {2'b00, 16'h5A5A};
            mem[4] = {2'b10, 16'h0000};
            run_prog("R8 R9 R10 hold", 36, 1'b0, 1'b0, 1'b0);
        end

        // R7: relative offsets backward and forward from the jump word
        for (int k = -3; k <= 3; k++) begin
            if (k == 0) continue;
            clear_mem();
            for (int a = 0; a < 8; a++) mem[a] = {2'b00, 16'(a + 1)};
            mem[4] = {2'b11, 16'(k)};
            mem[8] = {2'b10, 16'h0000};
            run_prog("R7 relative", 36, 1'b0, 1'b0, 1'b0);
        end

        // R5 R7: relative jump to 0xFFFF, then sequential wrap to 0x0000
        clear_mem();
        mem[0]   = {2'b00, 16'h0007};
        mem[1]   = {2'b11, 16'hFFFE};
        mem[255] = {2'b00, 16'h00FF};
        run_prog("R5 R7 wrap", 30, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule